// File: doc/BRIEF.md
# Serial Read-Only Memory Slave

This block is a read-only memory that answers on a three-wire serial bus. It has an active-low chip select, a serial clock, a serial data input and a serial data output. The master lowers chip select and clocks in a nine-byte header. The header starts with a read opcode. Next come three address bytes, which carry the upper address bits spread across several fields. A byte-address byte follows with the low seven bits, and the header ends with four dummy bytes whose values are ignored. After the header the slave shifts out bytes from a 1M x 8 array. It starts at the assembled address and keeps going, one address higher for each byte, for as long as the master supplies clock pulses. Raising chip select ends the transfer.

The serial bus lines are oversampled by a faster system clock. The array contents are a fixed arithmetic function of the address, so no storage or initialisation file is needed and any read can be predicted exactly. The output pin is released whenever the slave is not streaming data. A wrong opcode parks the slave in a silent standby state until the next chip-select cycle.

Top module: `sr_rom_slave`

## Requirements
- R1: The first byte after chip select falls is the opcode. Only 8'h52 starts a read, and 8'h52 is then followed by AD1, AD2, AD3, BA and the dummy bytes, in that order.
- R2: The 20-bit start address is built as A[19:17] = AD1[2:0], A[16:9] = AD2[7:0], A[8:7] = AD3[1:0] and A[6:0] = BA[6:0]. Every other header bit has no effect on the data returned.
- R3: Exactly four dummy bytes follow BA, and their values have no effect. The first data bit appears on so at the same SCLK rising edge that samples the last dummy bit.
- R4: Header bits on si are sampled on SCLK rising edges, and so changes only on SCLK rising edges. Both directions carry bit 7 first.
- R5: After each data byte the read address goes up by one, and it wraps from 20'hFFFFF to 20'h00000.
- R6: A first byte other than 8'h52 puts the slave in standby. In standby so_oe stays low for any amount of further SCLK activity, and the next chip-select cycle starts a fresh opcode.
- R7: While cs_n is high, so_oe is low. A rise of cs_n at any point, whether mid-header or mid-byte, abandons the transfer, and the next transfer decodes correctly.
- R8: The byte stored at address A is A[7:0] ^ A[15:8] ^ {4'h0, A[19:16]} ^ 8'hA5.
- R9: so_oe is high only during the data phase, from the edge that presents the first data bit until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sclk | input | 1 | Serial bus clock, synchronous to clk, much slower than clk |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Drive enable for so. When it is low the pad is released |

## Verification
The embedded properties check several things on every cycle. so_oe falls after cs_n goes high. The standby state holds while chip select stays low. The opcode state can only move to the first address state or to standby. so holds its value between SCLK rising edges. so_oe turns on only through the data-start pulse.

Some behaviour can only be shown by the scoreboard scenarios, because it needs a model of whole transfers:
- the scattered address assembly, with ones placed in every ignored bit;
- the content function;
- the increment and wrap across 20'hFFFFF;
- that dummy values are ignored;
- that transfers aborted mid-header and mid-byte leave no trace on the next read.

// File: rtl/sr_pkg.sv
// Shared types for the serial ROM slave.
// Assumes: one header field per byte, eight bits per byte.
package sr_pkg;

    typedef enum logic [2:0] {
        PH_OPC     = 3'd0,
        PH_AD1     = 3'd1,
        PH_AD2     = 3'd2,
        PH_AD3     = 3'd3,
        PH_BA      = 3'd4,
        PH_DUMMY   = 3'd5,
        PH_DATA    = 3'd6,
        PH_STANDBY = 3'd7
    } phase_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/sr_rom_func.sv
// Content generator: returns the byte stored at an address, computed
// as the XOR of all byte-wide slices of the zero-padded address and a key.
// Assumes: purely combinational; the caller registers the result.
module sr_rom_func #(
    parameter int              ADDR_W = 20,
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY  = 8'hA5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int NCH = (ADDR_W + DATA_W - 1) / DATA_W;

    logic [NCH*DATA_W-1:0] padded;
    logic [DATA_W-1:0]     slice [NCH];

    // Zero-extend the address to a whole number of slices.
    always_comb begin
        padded             = '0;
        padded[ADDR_W-1:0] = addr;
    end

    // One slice per generated lane.
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_slice
            assign slice[g] = padded[g*DATA_W +: DATA_W];
        end
    endgenerate

    // Fold all slices together with the key.
    always_comb begin
        data = KEY;
        for (int k = 0; k < NCH; k++) begin
            data = data ^ slice[k];
        end
    end

endmodule

// File: rtl/sr_hdr_ctrl.sv
// Header decoder: counts bits on each SCLK rise, checks the opcode,
// collects the scattered address fields, skips the dummy bytes and then
// paces the data phase with start/reload/shift strobes.
// Assumes: sclk_rise is a one-clk pulse; cs_n high clears all progress.
module sr_hdr_ctrl
    import sr_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter logic [7:0]  OPCODE      = 8'h52,
    parameter int          DUMMY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic              si,
    output logic              start,
    output logic              reload,
    output logic              shift,
    output logic [ADDR_W-1:0] rom_addr
);

    localparam int BA_W   = 7;
    localparam int AD3_W  = 2;
    localparam int AD2_W  = 8;
    localparam int AD1_W  = ADDR_W - BA_W - AD3_W - AD2_W;
    localparam int AD3_LO = BA_W;
    localparam int AD2_LO = BA_W + AD3_W;
    localparam int DCNT_W = (DUMMY_BYTES > 1) ? $clog2(DUMMY_BYTES) : 1;
    localparam logic [DCNT_W-1:0] DUMMY_LAST = DCNT_W'(DUMMY_BYTES - 1);

    phase_t              phase;
    logic [2:0]          bit_cnt;
    logic [BYTE_W-2:0]   rx_sh;
    logic [BYTE_W-1:0]   rx_byte;
    logic [DCNT_W-1:0]   dummy_cnt;
    logic [ADDR_W-1:0]   addr_q;
    logic                live_rise;
    logic                byte_done;

    // Qualify edges: ignored when deselected or in standby.
    always_comb begin
        live_rise = sclk_rise && !cs_n && (phase != PH_STANDBY);
        byte_done = live_rise && (bit_cnt == 3'd7);
        rx_byte   = {rx_sh, si};
    end

    // Phase sequencing, bit counting and the dummy-byte count.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase     <= PH_OPC;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            dummy_cnt <= '0;
        end else if (live_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sh   <= rx_byte[BYTE_W-2:0];
            if (byte_done) begin
                case (phase)
                    PH_OPC:   phase <= (rx_byte == OPCODE) ? PH_AD1 : PH_STANDBY;
                    PH_AD1:   phase <= PH_AD2;
                    PH_AD2:   phase <= PH_AD3;
                    PH_AD3:   phase <= PH_BA;
                    PH_BA: begin
                        phase     <= PH_DUMMY;
                        dummy_cnt <= '0;
                    end
                    PH_DUMMY: begin
                        if (dummy_cnt == DUMMY_LAST) phase <= PH_DATA;
                        else dummy_cnt <= dummy_cnt + 1'b1;
                    end
                    default:  phase <= phase;
                endcase
            end
        end
    end

    // Address register: loaded field by field, then stepped per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (byte_done) begin
            case (phase)
                PH_AD1:  addr_q[ADDR_W-1 -: AD1_W]  <= rx_byte[AD1_W-1:0];
                PH_AD2:  addr_q[AD2_LO +: AD2_W]    <= rx_byte[AD2_W-1:0];
                PH_AD3:  addr_q[AD3_LO +: AD3_W]    <= rx_byte[AD3_W-1:0];
                PH_BA:   addr_q[BA_W-1:0]           <= rx_byte[BA_W-1:0];
                PH_DATA: addr_q                     <= addr_q + 1'b1;
                default: addr_q                     <= addr_q;
            endcase
        end
    end

    // Strobes to the output shifter and the address it should fetch.
    always_comb begin
        start    = byte_done && (phase == PH_DUMMY) && (dummy_cnt == DUMMY_LAST);
        reload   = byte_done && (phase == PH_DATA);
        shift    = live_rise && !byte_done && (phase == PH_DATA);
        rom_addr = (phase == PH_DATA) ? addr_q + 1'b1 : addr_q;
    end

    // R6: standby persists while chip select stays low.
    p_standby_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STANDBY && !cs_n) |=> (phase == PH_STANDBY));

    // R1: the opcode phase leads only to the first address byte or standby.
    p_opc_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OPC && !cs_n) |=>
        (phase == PH_OPC || phase == PH_AD1 || phase == PH_STANDBY));

    // R7: deselect clears the phase and the bit counter.
    p_cs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_OPC && bit_cnt == 3'd0));

    // R4: the bit counter moves only on a serial clock rise.
    p_bit_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !cs_n) |=> $stable(bit_cnt));

    // R3: the data phase persists until deselect.
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !cs_n) |=> (phase == PH_DATA));

endmodule

// File: rtl/sr_tx_shift.sv
// Output shifter: holds the byte being sent, presents its MSB on so,
// and owns the drive enable, which is set by the start strobe.
// Assumes: start, reload and shift are mutually exclusive one-clk strobes.
module sr_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              start,
    input  logic              reload,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              so,
    output logic              so_oe
);

    logic [DATA_W-1:0] sh_q;
    logic              oe_q;

    // Load, shift or clear the outgoing byte; track the drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (start || reload) begin
            sh_q <= din;
            if (start) oe_q <= 1'b1;
        end else if (shift) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    assign so    = sh_q[DATA_W-1];
    assign so_oe = oe_q;

    // R4: so holds between serial clock rises.
    p_so_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !reload && !shift && !cs_n) |=> $stable(so));

    // R9: the drive enable rises only through the data-start strobe.
    p_oe_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(start));

endmodule

// File: rtl/sr_rom_slave.sv
// Top level: oversamples SCLK to find its rising edges, and ties together
// the header decoder, the content generator and the output shifter.
// Assumes: cs_n, sclk and si are already synchronous to clk and sclk
// stays at each level for at least two clk cycles.
module sr_rom_slave #(
    parameter int         ADDR_W      = 20,
    parameter int         DATA_W      = 8,
    parameter logic [7:0] OPCODE      = 8'h52,
    parameter int         DUMMY_BYTES = 4,
    parameter logic [7:0] ROM_KEY     = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic so,
    output logic so_oe
);

    logic              sclk_q;
    logic              sclk_rise;
    logic              start;
    logic              reload;
    logic              shift;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sclk_rise = sclk && !sclk_q;

    sr_hdr_ctrl #(
        .ADDR_W      (ADDR_W),
        .OPCODE      (OPCODE),
        .DUMMY_BYTES (DUMMY_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise),
        .si        (si),
        .start     (start),
        .reload    (reload),
        .shift     (shift),
        .rom_addr  (rom_addr)
    );

    sr_rom_func #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .KEY    (ROM_KEY)
    ) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    sr_tx_shift #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .start  (start),
        .reload (reload),
        .shift  (shift),
        .din    (rom_data),
        .so     (so),
        .so_oe  (so_oe)
    );

    // R7: deselect releases the output on the next cycle.
    p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);

endmodule

// File: tb/tb_sr_rom_slave.sv
// Scoreboard bench: the driver pushes predicted bytes into a queue and
// the monitor pops them as the slave shifts bytes out.
module tb_sr_rom_slave;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n  = 1'b1;
    logic sclk  = 1'b0;
    logic si    = 1'b0;
    logic so;
    logic so_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q [$];
    event       ev_sample;
    int         mon_bits = 0;
    logic [7:0] mon_byte = '0;
    bit         in_hdr   = 1'b0;
    bit         hdr_bad  = 1'b0;
    string      cur_req  = "R8";

    always #2 clk = ~clk;   // 250 MHz

    sr_rom_slave dut (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .si    (si),
        .so    (so),
        .so_oe (so_oe)
    );

    function automatic logic [7:0] rom_model(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: sample so just before each rising edge and score bytes.
    always @(ev_sample) begin
        if (in_hdr) begin
            if (so_oe) hdr_bad = 1'b1;
        end else if (so_oe) begin
            mon_byte = {mon_byte[6:0], so};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, {24'h0, mon_byte}, 32'hxx);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(mon_byte == e, cur_req, {24'h0, mon_byte}, {24'h0, e});
                end
            end
        end
    end

    task automatic sbit(input bit b);
        @(negedge clk);
        si = b;
        ->ev_sample;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sbyte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) sbit(b[i]);
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(so_oe == 1'b0, "R7", {31'h0, so_oe}, 0);
        mon_bits = 0;
        exp_q.delete();
        repeat (2) @(negedge clk);
    endtask

    // Full read with junk in every ignored bit; extra bits abort mid-byte.
    task automatic read_tx(input logic [19:0] a, input int nbytes,
                           input logic [7:0] junk, input int extra_bits,
                           input string req);
        cur_req = req;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        in_hdr  = 1'b1;
        hdr_bad = 1'b0;
        sbyte(8'h52);
        sbyte({junk[7:3], a[19:17]});
        sbyte(a[16:9]);
        sbyte({junk[5:0], a[8:7]});
        sbyte({junk[0], a[6:0]});
        for (int d = 0; d < 4; d++) sbyte(junk ^ 8'(d * 37));
        check(hdr_bad == 1'b0, "R9", {31'h0, hdr_bad}, 0);
        in_hdr = 1'b0;
        for (int k = 0; k < nbytes; k++) exp_q.push_back(rom_model(a + 20'(k)));
        for (int k = 0; k < nbytes; k++) sbyte(~junk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        for (int k = 0; k < extra_bits; k++) sbit(1'b1);
        deselect();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R7/R9: reset state releases the output.
        check(so_oe == 1'b0, "R9", {31'h0, so_oe}, 0);

        // R1, R2, R8, R4: plain reads, ignored bits all ones then all zeros.
        read_tx(20'h12345, 4, 8'hFF, 0, "R2");
        read_tx(20'hA5A5A, 3, 8'h00, 0, "R8");
        read_tx(20'h00000, 2, 8'h5C, 0, "R1");
        // R3: different dummy values give the same data.
        read_tx(20'h4C3B2, 3, 8'h3E, 0, "R3");
        // R5: increment across byte boundaries and wrap at the top.
        read_tx(20'hFFFFD, 6, 8'hC7, 0, "R5");
        read_tx(20'h0017E, 5, 8'h81, 0, "R5");

        // R6: wrong opcode, then a full valid-looking header and data clocks.
        cur_req = "R6";
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        in_hdr  = 1'b1;
        hdr_bad = 1'b0;
        sbyte(8'h53);
        sbyte(8'h52);
        for (int k = 0; k < 14; k++) sbyte(8'h52 ^ 8'(k));
        check(hdr_bad == 1'b0, "R6", {31'h0, hdr_bad}, 0);
        in_hdr = 1'b0;
        deselect();
        read_tx(20'h8F00F, 2, 8'h11, 0, "R6");

        // R7: abort mid-header, then a clean read.
        cur_req = "R7";
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        in_hdr = 1'b1;
        sbyte(8'h52);
        sbyte(8'h07);
        for (int k = 0; k < 3; k++) sbit(1'b1);
        in_hdr = 1'b0;
        deselect();
        read_tx(20'h3C0C3, 2, 8'h6A, 0, "R7");
        // R7: abort mid data byte, then a clean read.
        read_tx(20'h7FF80, 2, 8'h99, 3, "R7");
        read_tx(20'h00001, 3, 8'hF0, 0, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule